// File: doc/BRIEF.md
# Pulse-Synchronized Dual-Clock FIFO

This block is a small first-in first-out buffer whose writer and reader run on two unrelated clocks. It does not move pointer vectors between the domains. Each accepted write is sent to the read domain as one toggle event, and each accepted read is sent back the same way. On arrival the toggle becomes a single-cycle pulse. That pulse advances a local shadow copy of the other side's count. Each side therefore keeps its own pointer plus a shadow counter, and it derives full or empty from those two values.

A toggle event must not change again until the far domain has seen it. If it did, two strobes could merge into one and the counts would drift apart. Each side therefore raises a busy flag when it accepts a strobe. The flag stays up until an acknowledge toggle has made the round trip, so the spacing between strobes adapts on its own to whatever the clock ratio is. Strobes offered while busy, writes while full and reads while empty have no effect. Sustained throughput is therefore one transfer per handshake round trip, not one per clock.

Top module: `pulse_fifo`

## Requirements
- R1: After reset, rd_empty is 1, wr_full is 0, and both wr_busy and rd_busy are 0.
- R2: Words leave on rd_data in the order they were accepted on the write side.
- R3: Each accepted write adds exactly one readable word in the read domain. Once every accepted word has been read and the handshakes have settled, rd_empty returns to 1 and wr_full is 0.
- R4: An accepted write (wr_en=1, wr_full=0, wr_busy=0 at a wr_clk edge) sets wr_busy in the next wr_clk cycle. A write strobe offered while wr_busy is 1 is ignored and never reaches the read side.
- R5: An accepted read (rd_en=1, rd_empty=0, rd_busy=0 at a rd_clk edge) sets rd_busy in the next rd_clk cycle. A read strobe offered while rd_busy is 1 does not advance the read pointer.
- R6: wr_full is 1 once DEPTH words are held, as seen by the write domain. It is 0 with fewer words. A write offered while full is ignored and leaves wr_busy at 0.
- R7: A read offered while rd_empty is 1 is ignored and leaves rd_busy at 0.
- R8: While rd_empty is 0, rd_data already shows the oldest unread word before rd_en is raised.
- R9: After an accepted write, wr_busy stays high for at least SYNC_STAGES read-clock periods, and then clears without any further input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| wr_full | output | 1 | No free entry, as seen by the write domain |
| wr_busy | output | 1 | Previous write still in its handshake; new writes ignored |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read strobe (pops the word on rd_data) |
| rd_data | output | WIDTH | Oldest unread word (show-ahead) |
| rd_empty | output | 1 | No word visible to the read domain |
| rd_busy | output | 1 | Previous read still in its handshake; new reads ignored |

## Verification
On every cycle the assertions check four things. A strobe reaches a synchronizer only while that synchronizer is idle. An accepted strobe always raises busy. A recovered pulse never lasts two destination cycles. The occupancy seen by either domain never exceeds DEPTH. Other properties need the bench's scenarios with two unrelated clocks and a reference queue: that no strobe is lost or doubled over a long mixed sequence, that data order is preserved, that strobes offered while busy, full or empty leave no trace, and that the busy window spans enough read-clock periods.

// File: rtl/pf_pkg.sv
package pf_pkg;
   localparam int unsigned PF_MIN_STAGES = 2;

   function automatic bit pf_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pf_toggle_xfer.sv
module pf_toggle_xfer #(
   parameter int unsigned STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_strobe,
   output logic src_busy,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_pulse
);
   localparam int unsigned TOP = STAGES - 1;

   generate
      if (STAGES < pf_pkg::PF_MIN_STAGES) begin : g_bad_stages
         $error("pf_toggle_xfer: STAGES must be at least 2");
      end
   endgenerate

   logic              req_q;
   logic [STAGES-1:0] dst_sync;
   logic              dst_seen;
   logic [STAGES-1:0] ack_sync;

   // source: launch flop holds its level until the acknowledge returns
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n)      req_q <= 1'b0;
      else if (src_strobe) req_q <= ~req_q;
   end

   // destination: synchronizer chain plus one flop for edge detection
   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         dst_sync <= '0;
         dst_seen <= 1'b0;
      end else begin
         dst_sync <= {dst_sync[STAGES-2:0], req_q};
         dst_seen <= dst_sync[TOP];
      end
   end

   assign dst_pulse = dst_sync[TOP] ^ dst_seen;

   // acknowledge: the settled level goes back to the source
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) ack_sync <= '0;
      else            ack_sync <= {ack_sync[STAGES-2:0], dst_seen};
   end

   assign src_busy = req_q ^ ack_sync[TOP];

   // R4 R5
   strobe_when_idle_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      src_strobe |-> !src_busy);

   // R4 R5
   busy_after_strobe_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      src_strobe |=> src_busy);

   // R3
   pulse_isolated_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/pf_regfile.sv
module pf_regfile #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         always_ff @(posedge wclk) begin
            if (we && (waddr == AW'(i))) cells[i] <= wdata;
         end
      end
   endgenerate

   assign rdata = cells[raddr];
endmodule

// File: rtl/pulse_fifo.sv
module pulse_fifo #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             wr_rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             wr_full,
   output logic             wr_busy,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_empty,
   output logic             rd_busy
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   generate
      if (!pf_pkg::pf_is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("pulse_fifo: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pulse_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [PW-1:0] wr_ptr, rd_shadow;
   logic [PW-1:0] rd_ptr, wr_shadow;
   logic          wr_accept, rd_accept;
   logic          wr_evt_rd, rd_evt_wr;
   logic [PW-1:0] wr_level, rd_level;

   // write domain
   assign wr_level  = wr_ptr - rd_shadow;
   assign wr_full   = (wr_level == DEPTH_P);
   assign wr_accept = wr_en && !wr_full && !wr_busy;

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wr_ptr    <= '0;
         rd_shadow <= '0;
      end else begin
         if (wr_accept) wr_ptr    <= wr_ptr + 1'b1;
         if (rd_evt_wr) rd_shadow <= rd_shadow + 1'b1;
      end
   end

   // read domain
   assign rd_level  = wr_shadow - rd_ptr;
   assign rd_empty  = (wr_shadow == rd_ptr);
   assign rd_accept = rd_en && !rd_empty && !rd_busy;

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rd_ptr    <= '0;
         wr_shadow <= '0;
      end else begin
         if (rd_accept) rd_ptr    <= rd_ptr + 1'b1;
         if (wr_evt_rd) wr_shadow <= wr_shadow + 1'b1;
      end
   end

   pf_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .wclk  (wr_clk),
      .we    (wr_accept),
      .waddr (wr_ptr[AW-1:0]),
      .wdata (wr_data),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (rd_data)
   );

   pf_toggle_xfer #(.STAGES(SYNC_STAGES)) u_wr_xfer (
      .src_clk    (wr_clk),
      .src_rst_n  (wr_rst_n),
      .src_strobe (wr_accept),
      .src_busy   (wr_busy),
      .dst_clk    (rd_clk),
      .dst_rst_n  (rd_rst_n),
      .dst_pulse  (wr_evt_rd)
   );

   pf_toggle_xfer #(.STAGES(SYNC_STAGES)) u_rd_xfer (
      .src_clk    (rd_clk),
      .src_rst_n  (rd_rst_n),
      .src_strobe (rd_accept),
      .src_busy   (rd_busy),
      .dst_clk    (wr_clk),
      .dst_rst_n  (wr_rst_n),
      .dst_pulse  (rd_evt_wr)
   );

   // R6
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_level <= DEPTH_P);

   // R3
   no_phantom_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_level <= DEPTH_P);
endmodule

// File: tb/tb_pulse_fifo.sv
module tb_pulse_fifo;
   localparam int W = 8;
   localparam int D = 4;
   localparam int S = 2;
   localparam int RD_PERIOD = 7;

   logic wr_clk = 0, rd_clk = 0;
   logic wr_rst_n = 0, rd_rst_n = 0;
   logic wr_en = 0, rd_en = 0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic wr_full, wr_busy, rd_empty, rd_busy;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [W-1:0] ref_q [$];

   always #2 wr_clk = ~wr_clk;
   initial forever begin rd_clk = 1; #3; rd_clk = 0; #4; end

   pulse_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(S)) dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .wr_busy(wr_busy),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
      .rd_empty(rd_empty), .rd_busy(rd_busy));

   // bit 8: 1 = write the low byte, 0 = read and compare with the reference
   localparam logic [8:0] VEC [14] = '{
      9'h1A5, 9'h000, 9'h13C, 9'h1C3, 9'h000, 9'h000,
      9'h101, 9'h1FF, 9'h180, 9'h17E, 9'h000, 9'h000, 9'h000, 9'h000};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [W-1:0] d);
      @(negedge wr_clk);
      while (wr_busy || wr_full) @(negedge wr_clk);
      wr_en = 1; wr_data = d;
      @(negedge wr_clk);
      wr_en = 0;
      ref_q.push_back(d);
   endtask

   task automatic do_read();
      logic [W-1:0] exp;
      @(negedge rd_clk);
      while (rd_busy || rd_empty) @(negedge rd_clk);
      exp = ref_q.pop_front();
      // R2 R8: oldest word shown before the strobe
      check(rd_data == exp, "R2/R8 order", int'(rd_data), int'(exp));
      rd_en = 1;
      @(negedge rd_clk);
      rd_en = 0;
   endtask

   task automatic settle();
      repeat (30) @(negedge rd_clk);
      @(negedge wr_clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge wr_clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge wr_clk);
      wr_rst_n = 1; rd_rst_n = 1;
      @(negedge wr_clk);
      // R1
      check(rd_empty == 1, "R1 empty", rd_empty, 1);
      check(wr_full == 0, "R1 full", wr_full, 0);
      check(wr_busy == 0 && rd_busy == 0, "R1 busy", {wr_busy, rd_busy}, 0);

      // R7: read while empty
      @(negedge rd_clk); rd_en = 1; @(negedge rd_clk); rd_en = 0;
      check(rd_busy == 0, "R7 read-empty busy", rd_busy, 0);
      check(rd_empty == 1, "R7 read-empty", rd_empty, 1);

      // vector table walk
      foreach (VEC[i]) begin
         if (VEC[i][8]) do_write(VEC[i][7:0]);
         else           do_read();
      end
      settle();
      // R3
      check(rd_empty == 1, "R3 drained empty", rd_empty, 1);
      check(wr_full == 0, "R3 drained full", wr_full, 0);

      // R4 and R9: busy set, busy window, strobe while busy ignored
      begin
         longint t0, t1;
         do_write(8'h11);
         check(wr_busy == 1, "R4 busy set", wr_busy, 1);
         t0 = $time;
         wr_en = 1; wr_data = 8'hEE;
         @(negedge wr_clk);
         wr_en = 0;
         while (wr_busy) @(negedge wr_clk);
         t1 = $time;
         check((t1 - t0) >= S * RD_PERIOD, "R9 busy min", int'(t1 - t0), S * RD_PERIOD);
         check((t1 - t0) <= 12 * RD_PERIOD, "R9 busy clears", int'(t1 - t0), 12 * RD_PERIOD);
      end
      do_write(8'h22);
      do_read();
      do_read();
      settle();
      check(rd_empty == 1, "R4 busy write ignored", rd_empty, 1);

      // R6: fill to DEPTH
      for (int k = 0; k < D - 1; k++) do_write(8'h40 + 8'(k));
      check(wr_full == 0, "R6 not full", wr_full, 0);
      do_write(8'h4F);
      check(wr_full == 1, "R6 full", wr_full, 1);
      while (wr_busy) @(negedge wr_clk);
      wr_en = 1; wr_data = 8'h5A;
      @(negedge wr_clk);
      wr_en = 0;
      check(wr_busy == 0, "R6 write-full ignored", wr_busy, 0);
      for (int k = 0; k < D; k++) do_read();
      settle();
      check(rd_empty == 1 && wr_full == 0, "R6 drain", {rd_empty, wr_full}, 2);

      // R5: read while busy ignored
      do_write(8'h71);
      do_write(8'h72);
      do_read();
      check(rd_busy == 1, "R5 busy set", rd_busy, 1);
      rd_en = 1;
      @(negedge rd_clk);
      rd_en = 0;
      while (rd_busy) @(negedge rd_clk);
      check(rd_empty == 0, "R5 not popped", rd_empty, 0);
      check(rd_data == 8'h72, "R5 front kept", int'(rd_data), 'h72);
      do_read();
      settle();
      check(rd_empty == 1, "R3 final empty", rd_empty, 1);

      done = 1;
      summary();
      $finish;
   end
endmodule